// File: doc/BRIEF.md
# H-Bridge Current Chopping Decay Controller

This block steps one H-bridge through the phases of a fixed-off-time current chopper. Each cycle starts by driving the winding forward. Once the sensed current reaches the trip level, the bridge moves into a decay phase for a programmed off time. There are four decay policies: slow recirculation through both low-side switches, fast decay with reversed polarity, a fixed fast-then-slow mix, and an adaptive mix. The adaptive mix chooses fast or slow decay from the comparator state at the end of blanking.

An external indexer supplies several inputs: the trip-crossed and near-zero comparator flags, a flag that the target current is rising or holding, and a one-cycle pulse when the trip level moves, with its direction. The blanking, off and fast-decay durations are given in clock ticks. The output is a two-bit bridge command that names which switch set is on. Gate timing and dead time are handled further downstream.

Top module: `chop_decay_ctrl`

## Requirements
- R1: Bridge command encoding is 0 = all off, 1 = forward drive, 2 = reversed (fast decay), 3 = both low-side on (slow decay). A synchronous reset gives command 0. The first clock after reset release gives command 1.
- R2: For `blank_ticks` cycles after the bridge enters forward drive or fast decay, both comparator flags are ignored. With the trip flag held high, forward drive lasts `blank_ticks`+1 cycles.
- R3: In slow mode (`mode_sel` = 0), crossing the trip level after blanking gives command 3 for `off_ticks`+1 cycles. Forward drive follows.
- R4: If the current is below trip when blanking ends, drive continues until the trip flag rises. In adaptive mode (`mode_sel` = 3), slow decay then follows on the next cycle.
- R5: In fast mode (`mode_sel` = 1), if the near-zero flag stays low, command 2 lasts `off_ticks`+1 cycles and is followed by forward drive.
- R6: In fast decay, a near-zero flag seen after blanking switches the bridge off (command 0). The bridge stays off until the off time that started at decay entry runs out, then drives forward.
- R7: In fixed-mixed mode (`mode_sel` = 2), fast decay lasts `fast_ticks`+1 cycles. Slow decay fills the rest of the off time, which is `off_ticks`-`fast_ticks` cycles.
- R8: In fixed-mixed mode with `target_rising` high, the decay phase is slow decay only.
- R9: In adaptive mode, if the trip flag is high at the end of blanking, fast decay follows at once. Fast decay gives way to slow decay once the trip flag is low and a fresh blanking interval has elapsed. The whole decay still lasts `off_ticks`+1 cycles.
- R10: In adaptive mode, if the trip flag stays high through fast decay, the bridge remains in fast decay until the off time expires.
- R11: When `indexer_en` is low, modes 2 and 3 act as slow decay. Mode 1 still gives fast decay.
- R12: A trip-level pulse with `trip_up` high gives forward drive on the next cycle, from any phase, even while blanking is running.
- R13: A trip-level pulse with `trip_up` low gives fast decay on the next cycle and restarts the off time, so fast decay then lasts `off_ticks`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Decay policy: 0 slow, 1 fast, 2 fixed mixed, 3 adaptive |
| indexer_en | input | 1 | Indexer operation; allows the mixed policies |
| blank_ticks | input | BLANK_W | Blanking length in ticks |
| off_ticks | input | TIME_W | Fixed off time in ticks |
| fast_ticks | input | TIME_W | Fast part of fixed mixed decay in ticks |
| over_trip | input | 1 | Current at or above trip level |
| near_zero | input | 1 | Winding current close to zero |
| target_rising | input | 1 | Target current rising or holding |
| trip_change | input | 1 | One-cycle pulse: trip level changed |
| trip_up | input | 1 | Direction of the change, 1 = raised |
| bridge_cmd | output | 2 | Bridge switch-set command |

## Verification
The bench builds the block with BLANK_W = 4 and TIME_W = 5 and runs it with a blanking of 3 ticks, an off time of 10 and a fast time of 4. These short windows let each phase length be counted cycle by cycle, with distinct values that differ from one another. A blanking or off time that is off by one therefore shows up in the measured length. The small widths also keep every mixed-decay split within a few dozen cycles, and each scenario is run from a fresh reset.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [1:0] {
        BR_OFF  = 2'd0,
        BR_FWD  = 2'd1,
        BR_REV  = 2'd2,
        BR_LOWS = 2'd3
    } bridge_e;

    typedef enum logic [1:0] {
        DM_SLOW  = 2'd0,
        DM_FAST  = 2'd1,
        DM_MIXED = 2'd2,
        DM_AUTO  = 2'd3
    } decay_e;

    typedef struct packed {
        bridge_e phase;
        logic    sampled;
    } ctl_s;
endpackage

// File: rtl/chop_mode_sel.sv
module chop_mode_sel
    import chop_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       indexer_en,
    input  logic       target_rising,
    output decay_e     eff_mode
);
    always_comb begin
        case (mode_sel)
            2'd0:    eff_mode = DM_SLOW;
            2'd1:    eff_mode = DM_FAST;
            2'd2:    eff_mode = (indexer_en && !target_rising) ? DM_MIXED : DM_SLOW;
            default: eff_mode = indexer_en ? DM_AUTO : DM_SLOW;
        endcase
    end
endmodule

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/chop_decay_ctrl.sv
module chop_decay_ctrl
    import chop_pkg::*;
#(
    parameter int BLANK_W = 8,
    parameter int TIME_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode_sel,
    input  logic               indexer_en,
    input  logic [BLANK_W-1:0] blank_ticks,
    input  logic [TIME_W-1:0]  off_ticks,
    input  logic [TIME_W-1:0]  fast_ticks,
    input  logic               over_trip,
    input  logic               near_zero,
    input  logic               target_rising,
    input  logic               trip_change,
    input  logic               trip_up,
    output logic [1:0]         bridge_cmd
);
    ctl_s   ctl_d, ctl_q;
    decay_e eff_mode;
    logic   blank_exp, off_exp, fast_exp;
    logic   enter_d, ld_off_d, ld_blank_d, ld_fast_d;

    chop_mode_sel u_mode (
        .mode_sel      (mode_sel),
        .indexer_en    (indexer_en),
        .target_rising (target_rising),
        .eff_mode      (eff_mode)
    );

    chop_timer #(.W(BLANK_W)) u_blank (
        .clk (clk), .rst (rst), .load (ld_blank_d),
        .load_val (blank_ticks), .expired (blank_exp)
    );

    chop_timer #(.W(TIME_W)) u_off (
        .clk (clk), .rst (rst), .load (ld_off_d),
        .load_val (off_ticks), .expired (off_exp)
    );

    chop_timer #(.W(TIME_W)) u_fast (
        .clk (clk), .rst (rst), .load (ld_fast_d),
        .load_val (fast_ticks), .expired (fast_exp)
    );

    always_comb begin
        ctl_d    = ctl_q;
        enter_d  = 1'b0;
        ld_off_d = 1'b0;
        if (trip_change) begin
            enter_d = 1'b1;
            if (trip_up) begin
                ctl_d.phase = BR_FWD;
            end else begin
                ctl_d.phase = BR_REV;
                ld_off_d    = 1'b1;
            end
        end else begin
            case (ctl_q.phase)
                BR_OFF: begin
                    if (off_exp) ctl_d.phase = BR_FWD;
                end
                BR_FWD: begin
                    if (blank_exp) begin
                        ctl_d.sampled = 1'b1;
                        if (over_trip) begin
                            ld_off_d = 1'b1;
                            case (eff_mode)
                                DM_SLOW:  ctl_d.phase = BR_LOWS;
                                DM_FAST:  ctl_d.phase = BR_REV;
                                DM_MIXED: ctl_d.phase = BR_REV;
                                DM_AUTO:  ctl_d.phase = ctl_q.sampled ? BR_LOWS : BR_REV;
                            endcase
                        end
                    end
                end
                BR_REV: begin
                    if (blank_exp && near_zero)
                        ctl_d.phase = BR_OFF;
                    else if (off_exp)
                        ctl_d.phase = BR_FWD;
                    else if (eff_mode == DM_MIXED && fast_exp)
                        ctl_d.phase = BR_LOWS;
                    else if (eff_mode == DM_AUTO && blank_exp && !over_trip)
                        ctl_d.phase = BR_LOWS;
                end
                BR_LOWS: begin
                    if (off_exp) ctl_d.phase = BR_FWD;
                end
            endcase
        end
        if (ctl_d.phase != ctl_q.phase) enter_d = 1'b1;
        if (enter_d && ctl_d.phase == BR_FWD) ctl_d.sampled = 1'b0;
        ld_blank_d = enter_d && (ctl_d.phase == BR_FWD || ctl_d.phase == BR_REV);
        ld_fast_d  = enter_d && (ctl_d.phase == BR_REV);
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{phase: BR_OFF, sampled: 1'b0};
        else     ctl_q <= ctl_d;
    end

    assign bridge_cmd = ctl_q.phase;
endmodule

// File: rtl/chop_decay_chk.sv
module chop_decay_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       indexer_en,
    input logic       target_rising,
    input logic       trip_change,
    input logic       trip_up,
    input logic [1:0] bridge_cmd
);
    // R1
    reset_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> bridge_cmd == 2'd0);

    // R12
    raise_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (trip_change && trip_up) |=> bridge_cmd == 2'd1);

    // R13
    lower_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (trip_change && !trip_up) |=> bridge_cmd == 2'd2);

    // R11
    noidx_no_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd == 2'd1 && !trip_change && !indexer_en && mode_sel != 2'd1)
        |=> bridge_cmd != 2'd2);

    // R8
    rising_slow_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd == 2'd1 && !trip_change && mode_sel == 2'd2 && target_rising)
        |=> bridge_cmd != 2'd2);

    // R3
    slow_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd == 2'd3 && !trip_change) |=> (bridge_cmd == 2'd3 || bridge_cmd == 2'd1));

    // R6
    off_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (bridge_cmd == 2'd0 && !trip_change) |=> (bridge_cmd == 2'd0 || bridge_cmd == 2'd1));
endmodule

bind chop_decay_ctrl chop_decay_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mode_sel      (mode_sel),
    .indexer_en    (indexer_en),
    .target_rising (target_rising),
    .trip_change   (trip_change),
    .trip_up       (trip_up),
    .bridge_cmd    (bridge_cmd)
);

// File: tb/chop_decay_ctrl_bench.sv
module chop_decay_ctrl_bench;
    localparam int BW = 4;
    localparam int TW = 5;
    localparam int B  = 3;
    localparam int O  = 10;
    localparam int F  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_sel = 2'd0;
    logic          indexer_en = 1'b1;
    logic [BW-1:0] blank_ticks = BW'(B);
    logic [TW-1:0] off_ticks = TW'(O);
    logic [TW-1:0] fast_ticks = TW'(F);
    logic          over_trip = 1'b0;
    logic          near_zero = 1'b0;
    logic          target_rising = 1'b0;
    logic          trip_change = 1'b0;
    logic          trip_up = 1'b0;
    logic [1:0]    bridge_cmd;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    chop_decay_ctrl #(.BLANK_W(BW), .TIME_W(TW)) u_chop_decay_ctrl (
        .clk (clk), .rst (rst), .mode_sel (mode_sel), .indexer_en (indexer_en),
        .blank_ticks (blank_ticks), .off_ticks (off_ticks), .fast_ticks (fast_ticks),
        .over_trip (over_trip), .near_zero (near_zero), .target_rising (target_rising),
        .trip_change (trip_change), .trip_up (trip_up), .bridge_cmd (bridge_cmd)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic measure(output int n);
        logic [1:0] c0;
        c0 = bridge_cmd;
        n  = 0;
        do begin
            tick(1);
            n++;
        end while (bridge_cmd == c0 && n < 100);
    endtask

    task automatic start(int m, bit idx, bit ot, bit nz, bit rise);
        mode_sel = 2'(m); indexer_en = idx; over_trip = ot;
        near_zero = nz; target_rising = rise;
        trip_change = 1'b0; trip_up = 1'b0;
        rst = 1'b1;
        tick(2);
        chk("R1 reset off", bridge_cmd, 0);
        rst = 1'b0;
        tick(1);
        chk("R1 drive after reset", bridge_cmd, 1);
    endtask

    task automatic t_slow();
        int n;
        start(0, 1, 1, 0, 0);
        measure(n);
        chk("R2 blanked drive length", n, B + 1);
        chk("R3 slow decay entered", bridge_cmd, 3);
        measure(n);
        chk("R3 slow decay length", n, O + 1);
        chk("R3 drive after off", bridge_cmd, 1);
    endtask

    task automatic t_drive_hold();
        start(3, 1, 0, 0, 0);
        tick(6);
        chk("R4 drive held below trip", bridge_cmd, 1);
        over_trip = 1'b1;
        tick(1);
        chk("R4 late trip gives slow", bridge_cmd, 3);
    endtask

    task automatic t_fast();
        int n;
        start(1, 1, 1, 0, 0);
        measure(n);
        chk("R5 drive length", n, B + 1);
        chk("R5 fast entered", bridge_cmd, 2);
        measure(n);
        chk("R5 fast length", n, O + 1);
        chk("R5 drive after fast", bridge_cmd, 1);
    endtask

    task automatic t_near_zero();
        int n;
        start(1, 1, 1, 1, 0);
        measure(n);
        chk("R6 near zero ignored in drive", n, B + 1);
        measure(n);
        chk("R2 near zero blanked in fast", n, B + 1);
        chk("R6 bridge disabled", bridge_cmd, 0);
        measure(n);
        chk("R6 disabled until off expiry", n, O - B);
        chk("R6 drive after disabled", bridge_cmd, 1);
    endtask

    task automatic t_mixed();
        int n;
        start(2, 1, 1, 0, 0);
        measure(n);
        chk("R7 mixed starts fast", bridge_cmd, 2);
        measure(n);
        chk("R7 fast part length", n, F + 1);
        chk("R7 slow part entered", bridge_cmd, 3);
        measure(n);
        chk("R7 slow part length", n, O - F);
        chk("R7 drive after mixed", bridge_cmd, 1);
    endtask

    task automatic t_rising();
        int n;
        start(2, 1, 1, 0, 1);
        measure(n);
        chk("R8 rising target slow only", bridge_cmd, 3);
        measure(n);
        chk("R8 slow fills off time", n, O + 1);
    endtask

    task automatic t_auto();
        int n;
        start(3, 1, 1, 0, 0);
        measure(n);
        chk("R9 auto fast at blank end", bridge_cmd, 2);
        over_trip = 1'b0;
        measure(n);
        chk("R9 fast until below trip plus blank", n, B + 1);
        chk("R9 slow after fast", bridge_cmd, 3);
        measure(n);
        chk("R9 slow remainder", n, O - B);
        chk("R9 drive after auto", bridge_cmd, 1);
    endtask

    task automatic t_auto_hold();
        int n;
        start(3, 1, 1, 0, 0);
        measure(n);
        chk("R10 auto fast entered", bridge_cmd, 2);
        measure(n);
        chk("R10 fast held full off time", n, O + 1);
        chk("R10 drive after fast", bridge_cmd, 1);
    endtask

    task automatic t_no_indexer();
        int n;
        start(2, 0, 1, 0, 0);
        measure(n);
        chk("R11 fixed mixed falls back", bridge_cmd, 3);
        start(3, 0, 1, 0, 0);
        measure(n);
        chk("R11 auto falls back", bridge_cmd, 3);
        start(1, 0, 1, 0, 0);
        measure(n);
        chk("R11 fast kept", bridge_cmd, 2);
    endtask

    task automatic t_raise();
        int n;
        start(0, 1, 1, 0, 0);
        measure(n);
        chk("R12 in slow before raise", bridge_cmd, 3);
        tick(2);
        trip_change = 1'b1; trip_up = 1'b1; over_trip = 1'b0;
        tick(1);
        trip_change = 1'b0;
        chk("R12 raise forces drive", bridge_cmd, 1);
        tick(5);
        chk("R12 drive holds below trip", bridge_cmd, 1);
    endtask

    task automatic t_lower();
        int n;
        start(0, 1, 0, 0, 0);
        tick(1);
        trip_change = 1'b1; trip_up = 1'b0;
        tick(1);
        trip_change = 1'b0;
        chk("R13 lower forces fast in blanking", bridge_cmd, 2);
        measure(n);
        chk("R13 off time restarted", n, O + 1);
        chk("R13 drive after forced fast", bridge_cmd, 1);
    endtask

    initial begin
        #(4 * 20000);
        fails++;
        total++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_slow();
        t_drive_hold();
        t_fast();
        t_near_zero();
        t_mixed();
        t_rising();
        t_auto();
        t_auto_hold();
        t_no_indexer();
        t_raise();
        t_lower();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule